// File: doc/BRIEF.md
# Pipelined Store-Hit Path for a Direct-Mapped Cache

This block is the store side of a direct-mapped data cache, arranged so that a store that hits costs the processor a single cycle, the same as a load hit. A store cannot write the data array while its tag is still being compared, because a mismatch would corrupt another address's line. The block therefore splits the store across two stages. In the request cycle it checks the tag and, on a match, releases the processor at once. The accepted store is parked in a delayed-write register. Its bytes reach the data array on a later clock edge, overlapped with whatever access comes next.

Every request is resolved combinationally in the cycle it is presented. A load that hits the line held in the delayed-write register sees the parked bytes merged over the array word. A store that hits while a write is already parked retires the older write on the same edge that captures the new one, so back-to-back stores never stall. Line replacement is outside this block. A miss is only reported on `rsp_miss`. The refill logic installs a line through the fill port, and that port also retires or discards any parked write.

Top module: `wr_pipe_top`

## Requirements
- R1: After a synchronous active-low reset, every line is invalid and no write is parked. Every later request misses until a fill installs a line. With `req_valid` low, `rsp_ready`, `rsp_miss` and `rsp_rdata` are all zero.
- R2: A load (`req_we`=0) whose line is valid and whose tag (address bits above the index) matches raises `rsp_ready`, keeps `rsp_miss` low and returns the stored word on `rsp_rdata`, all in the same cycle.
- R3: A request whose line is invalid or holds another tag raises `rsp_miss`, keeps `rsp_ready` low and drives `rsp_rdata` to zero. `rsp_ready` and `rsp_miss` are never high together.
- R4: A store (`req_we`=1) that hits raises `rsp_ready` in the same cycle and drives `rsp_rdata` to zero. Its bytes are held in the delayed-write register and become visible to later loads.
- R5: A store that misses changes neither the data array nor the parked write. Loads to the previously parked address still return the parked bytes.
- R6: A load that matches the index and tag of the parked write returns, for each byte lane i (bits 8i+7:8i, enabled by `req_be[i]` of that store), the parked byte where its enable was set and the array byte elsewhere.
- R7: A store hit while a write is parked first commits the older write to the array and then parks the new one, with no stall. Both sets of bytes are then visible.
- R8: A fill writes the tag, valid bit and word of the line selected by `fill_addr`. A parked write is retired on the fill edge: to the array if the fill goes to another line, overwritten by the fill data if it goes to the same line. A request presented in the same cycle as a fill is reported as a miss.
- R9: With `req_valid` low, the inputs `req_we`, `req_addr`, `req_wdata` and `req_be` have no effect on the array or on the parked write.
- R10: A store hit with an all-zero byte mask leaves every byte of the line unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all state updates on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Processor request present this cycle |
| req_we | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Byte address of the request |
| req_wdata | input | DATA_W | Store data |
| req_be | input | DATA_W/8 | Store byte enables, bit i selects byte lane i |
| fill_valid | input | 1 | Refill logic installs a line this cycle |
| fill_addr | input | ADDR_W | Byte address of the installed line |
| fill_data | input | DATA_W | Word written into the installed line |
| rsp_ready | output | 1 | Request hit and the processor may continue |
| rsp_miss | output | 1 | Request missed, stall for the refill path |
| rsp_rdata | output | DATA_W | Load hit data, zero otherwise |

## Verification
A parked write that is lost, retired late or retired twice does not show up on the store's own cycle. It shows up at the next load to that word, which returns the older array bytes or a merge built from the wrong mask. The vector sequence therefore always follows a store, a store miss or a fill with loads to both the parked address and a neighbouring line. A wrong valid or tag bit shows up at the first request to that index, as a response on the wrong one of `rsp_ready` and `rsp_miss`. The conflict cases cover a fill to the parked line, a fill to another line, a store miss to the parked line's index and a zero-mask store. Each one changes the next load result when the retire ordering is wrong.

// File: rtl/wr_pipe_pkg.sv
// Shared types for the pipelined store-hit path.
// Assumes: nothing beyond the definitions below.
package wr_pipe_pkg;

    // Kind of processor access seen in the request stage.
    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_LOAD  = 2'd1,
        ACC_STORE = 2'd2
    } acc_kind_e;

    // Default geometry.
    localparam int unsigned DEF_ADDR_W = 16;
    localparam int unsigned DEF_DATA_W = 32;
    localparam int unsigned DEF_LINES  = 64;

endpackage

// File: rtl/wr_tag_store.sv
// Tag and valid storage with a combinational lookup.
// Each line keeps one tag and one valid bit. The lookup compares one index/tag
// pair per cycle. A fill writes tag and valid on the clock edge.
// Assumes: one fill per cycle at most; reset is synchronous, active low.
module wr_tag_store #(
    parameter int unsigned LINES = 64,
    parameter int unsigned TAG_W = 8,
    localparam int unsigned IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] lk_idx,
    input  logic [TAG_W-1:0] lk_tag,
    output logic             lk_hit,
    input  logic             fill_en,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic [TAG_W-1:0] fill_tag
);

    logic [TAG_W-1:0] tag_q [LINES];
    logic [LINES-1:0] vld_q;

    // Valid bits: cleared by reset, set by fills.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else if (fill_en) begin
            vld_q[fill_idx] <= 1'b1;
        end
    end

    // Tag words: written by fills, no reset needed behind the valid bits.
    always_ff @(posedge clk) begin
        if (fill_en) begin
            tag_q[fill_idx] <= fill_tag;
        end
    end

    // Lookup: hit when the selected line is valid and its tag matches.
    always_comb begin
        lk_hit = vld_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
    end

    // R8
    fill_sets_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> vld_q[$past(fill_idx)]);

    // R1
    reset_clears_valid_chk: assert property (@(posedge clk)
        !rst_n |=> (vld_q == '0));

endmodule

// File: rtl/wr_data_array.sv
// Word-per-line data storage.
// The read port is combinational. There are two write sources on the same
// edge: a byte-masked commit from the delayed-write register, then a whole-word
// fill. The fill lands last, so it wins when both target the same line.
// Assumes: the caller only raises cm_en for a write whose tag already hit.
module wr_data_array #(
    parameter int unsigned LINES  = 64,
    parameter int unsigned DATA_W = 32,
    localparam int unsigned IDX_W = $clog2(LINES),
    localparam int unsigned BE_W  = DATA_W / 8
) (
    input  logic              clk,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_word,
    input  logic              cm_en,
    input  logic [IDX_W-1:0]  cm_idx,
    input  logic [DATA_W-1:0] cm_data,
    input  logic [BE_W-1:0]   cm_be,
    input  logic              fill_en,
    input  logic [IDX_W-1:0]  fill_idx,
    input  logic [DATA_W-1:0] fill_data
);

    logic [DATA_W-1:0] mem_q [LINES];

    // Array update: masked commit first, then a fill overwrites its line.
    always_ff @(posedge clk) begin
        if (cm_en) begin
            for (int b = 0; b < BE_W; b++) begin
                if (cm_be[b]) begin
                    mem_q[cm_idx][b*8 +: 8] <= cm_data[b*8 +: 8];
                end
            end
        end
        if (fill_en) begin
            mem_q[fill_idx] <= fill_data;
        end
    end

    // Combinational read of the addressed line.
    always_comb begin
        rd_word = mem_q[rd_idx];
    end

endmodule

// File: rtl/wr_delay_reg.sv
// Delayed-write register with load bypass.
// Holds at most one store that has passed its tag check. The store is retired
// on the edge of the next store hit or the next fill, and a load to the same
// index and tag sees its enabled bytes merged over the array word.
// Assumes: cap_en and fill_en are never high together (the top masks hits
// during fills).
module wr_delay_reg #(
    parameter int unsigned LINES  = 64,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned TAG_W  = 8,
    localparam int unsigned IDX_W = $clog2(LINES),
    localparam int unsigned BE_W  = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic [IDX_W-1:0]  cap_idx,
    input  logic [TAG_W-1:0]  cap_tag,
    input  logic [DATA_W-1:0] cap_data,
    input  logic [BE_W-1:0]   cap_be,
    input  logic              fill_en,
    input  logic              st_miss,
    output logic              cm_en,
    output logic [IDX_W-1:0]  cm_idx,
    output logic [DATA_W-1:0] cm_data,
    output logic [BE_W-1:0]   cm_be,
    output logic              pend_vld,
    input  logic [IDX_W-1:0]  ld_idx,
    input  logic [TAG_W-1:0]  ld_tag,
    input  logic [DATA_W-1:0] arr_word,
    output logic [DATA_W-1:0] ld_word
);

    logic              vld_q;
    logic [IDX_W-1:0]  idx_q;
    logic [TAG_W-1:0]  tag_q;
    logic [DATA_W-1:0] data_q;
    logic [BE_W-1:0]   be_q;
    logic              ld_match;

    // Valid flag: set by a capture, cleared by a fill, kept otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= 1'b0;
        end else if (cap_en) begin
            vld_q <= 1'b1;
        end else if (fill_en) begin
            vld_q <= 1'b0;
        end
    end

    // Payload: loaded with the accepted store's location, data and mask.
    always_ff @(posedge clk) begin
        if (cap_en) begin
            idx_q  <= cap_idx;
            tag_q  <= cap_tag;
            data_q <= cap_data;
            be_q   <= cap_be;
        end
    end

    // Retire: the parked write goes to the array when it is displaced.
    always_comb begin
        cm_en   = vld_q && (cap_en || fill_en);
        cm_idx  = idx_q;
        cm_data = data_q;
        cm_be   = be_q;
    end

    // Bypass match: the load addresses the parked word.
    always_comb begin
        ld_match = vld_q && (ld_idx == idx_q) && (ld_tag == tag_q);
    end

    // Bypass merge, one lane per byte.
    for (genvar b = 0; b < BE_W; b++) begin : g_lane
        always_comb begin
            ld_word[b*8 +: 8] = (ld_match && be_q[b]) ? data_q[b*8 +: 8]
                                                      : arr_word[b*8 +: 8];
        end
    end

    assign pend_vld = vld_q;

    // R1
    reset_no_pending_chk: assert property (@(posedge clk)
        !rst_n |=> !vld_q);

    // R5
    store_miss_keeps_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_miss && !fill_en) |=> ($stable(vld_q) && $stable(data_q) && $stable(be_q)));

    // R8
    fill_retires_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && !cap_en) |=> !vld_q);

    // R7
    capture_while_parked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_q && cap_en) |-> cm_en);

endmodule

// File: rtl/wr_pipe_top.sv
// Pipelined store-hit path of a direct-mapped cache.
// Stage 1 (request cycle) decodes the address, checks the tag and answers the
// processor. A store hit is captured into the delayed-write register. Stage 2
// writes the array later, on the edge of the next store hit or fill.
// Assumes: byte addresses, one word per line; address = {tag, index, offset}.
module wr_pipe_top
    import wr_pipe_pkg::*;
#(
    parameter int unsigned ADDR_W = DEF_ADDR_W,
    parameter int unsigned DATA_W = DEF_DATA_W,
    parameter int unsigned LINES  = DEF_LINES,
    localparam int unsigned BE_W  = DATA_W / 8,
    localparam int unsigned OFF_W = $clog2(BE_W),
    localparam int unsigned IDX_W = $clog2(LINES),
    localparam int unsigned TAG_W = ADDR_W - IDX_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [BE_W-1:0]   req_be,
    input  logic              fill_valid,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic [DATA_W-1:0] fill_data,
    output logic              rsp_ready,
    output logic              rsp_miss,
    output logic [DATA_W-1:0] rsp_rdata
);

    acc_kind_e         kind;
    logic [IDX_W-1:0]  rq_idx;
    logic [TAG_W-1:0]  rq_tag;
    logic [IDX_W-1:0]  fl_idx;
    logic [TAG_W-1:0]  fl_tag;
    logic              tag_hit;
    logic              line_hit;
    logic              st_cap;
    logic              st_miss;
    logic              cm_en;
    logic [IDX_W-1:0]  cm_idx;
    logic [DATA_W-1:0] cm_data;
    logic [BE_W-1:0]   cm_be;
    logic              pend_vld;
    logic [DATA_W-1:0] arr_word;
    logic [DATA_W-1:0] ld_word;

    // Address split for request and fill.
    always_comb begin
        rq_idx = req_addr[OFF_W +: IDX_W];
        rq_tag = req_addr[ADDR_W-1 -: TAG_W];
        fl_idx = fill_addr[OFF_W +: IDX_W];
        fl_tag = fill_addr[ADDR_W-1 -: TAG_W];
    end

    // Access classification.
    always_comb begin
        if (!req_valid)  kind = ACC_IDLE;
        else if (req_we) kind = ACC_STORE;
        else             kind = ACC_LOAD;
    end

    // Hit qualification: a fill in flight forces a miss this cycle.
    always_comb begin
        line_hit = tag_hit && !fill_valid;
        st_cap   = (kind == ACC_STORE) && line_hit;
        st_miss  = (kind == ACC_STORE) && !line_hit;
    end

    // Processor response, all resolved in the request cycle.
    always_comb begin
        rsp_ready = (kind != ACC_IDLE) && line_hit;
        rsp_miss  = (kind != ACC_IDLE) && !line_hit;
        rsp_rdata = ((kind == ACC_LOAD) && line_hit) ? ld_word : '0;
    end

    wr_tag_store #(
        .LINES (LINES),
        .TAG_W (TAG_W)
    ) u_tags (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_idx   (rq_idx),
        .lk_tag   (rq_tag),
        .lk_hit   (tag_hit),
        .fill_en  (fill_valid),
        .fill_idx (fl_idx),
        .fill_tag (fl_tag)
    );

    wr_delay_reg #(
        .LINES  (LINES),
        .DATA_W (DATA_W),
        .TAG_W  (TAG_W)
    ) u_dwr (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_en   (st_cap),
        .cap_idx  (rq_idx),
        .cap_tag  (rq_tag),
        .cap_data (req_wdata),
        .cap_be   (req_be),
        .fill_en  (fill_valid),
        .st_miss  (st_miss),
        .cm_en    (cm_en),
        .cm_idx   (cm_idx),
        .cm_data  (cm_data),
        .cm_be    (cm_be),
        .pend_vld (pend_vld),
        .ld_idx   (rq_idx),
        .ld_tag   (rq_tag),
        .arr_word (arr_word),
        .ld_word  (ld_word)
    );

    wr_data_array #(
        .LINES  (LINES),
        .DATA_W (DATA_W)
    ) u_arr (
        .clk       (clk),
        .rd_idx    (rq_idx),
        .rd_word   (arr_word),
        .cm_en     (cm_en),
        .cm_idx    (cm_idx),
        .cm_data   (cm_data),
        .cm_be     (cm_be),
        .fill_en   (fill_valid),
        .fill_idx  (fl_idx),
        .fill_data (fill_data)
    );

    // R3
    ready_miss_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_ready && rsp_miss));

    // R4
    store_hit_parks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_ready && req_we && !fill_valid) |=> pend_vld);

    // R9
    idle_no_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid && !fill_valid) |=> $stable(pend_vld));

endmodule

// File: tb/sim_wr_pipe_top.sv
`timescale 1ns/1ps
module sim_wr_pipe_top;

    localparam int unsigned AW = 16;
    localparam int unsigned DW = 32;
    localparam int unsigned NV = 21;

    // Row: kind(2) 0=load 1=store 2=fill | addr(16) | data(32) | be(4) |
    //      exp_ready | exp_miss | exp_rdata(32)
    localparam logic [87:0] VEC [NV] = '{
        {2'd0, 16'h1204, 32'h0000_0000, 4'h0, 1'b0, 1'b1, 32'h0000_0000},
        {2'd2, 16'h1204, 32'h1122_3344, 4'h0, 1'b0, 1'b0, 32'h0000_0000},
        {2'd0, 16'h1204, 32'h0000_0000, 4'h0, 1'b1, 1'b0, 32'h1122_3344},
        {2'd1, 16'h1204, 32'hAABB_CCDD, 4'h1, 1'b1, 1'b0, 32'h0000_0000},
        {2'd0, 16'h1204, 32'h0000_0000, 4'h0, 1'b1, 1'b0, 32'h1122_33DD},
        {2'd0, 16'h3404, 32'h0000_0000, 4'h0, 1'b0, 1'b1, 32'h0000_0000},
        {2'd1, 16'h3404, 32'h0000_0000, 4'hF, 1'b0, 1'b1, 32'h0000_0000},
        {2'd0, 16'h1204, 32'h0000_0000, 4'h0, 1'b1, 1'b0, 32'h1122_33DD},
        {2'd2, 16'h1208, 32'h5566_7788, 4'h0, 1'b0, 1'b0, 32'h0000_0000},
        {2'd0, 16'h1204, 32'h0000_0000, 4'h0, 1'b1, 1'b0, 32'h1122_33DD},
        {2'd1, 16'h1208, 32'h00EE_0000, 4'h4, 1'b1, 1'b0, 32'h0000_0000},
        {2'd1, 16'h1208, 32'h0000_FF00, 4'h2, 1'b1, 1'b0, 32'h0000_0000},
        {2'd0, 16'h1208, 32'h0000_0000, 4'h0, 1'b1, 1'b0, 32'h55EE_FF88},
        {2'd1, 16'h1204, 32'h9900_0000, 4'h8, 1'b1, 1'b0, 32'h0000_0000},
        {2'd0, 16'h1208, 32'h0000_0000, 4'h0, 1'b1, 1'b0, 32'h55EE_FF88},
        {2'd0, 16'h1204, 32'h0000_0000, 4'h0, 1'b1, 1'b0, 32'h9922_33DD},
        {2'd2, 16'h3404, 32'hCAFE_F00D, 4'h0, 1'b0, 1'b0, 32'h0000_0000},
        {2'd0, 16'h1204, 32'h0000_0000, 4'h0, 1'b0, 1'b1, 32'h0000_0000},
        {2'd0, 16'h3404, 32'h0000_0000, 4'h0, 1'b1, 1'b0, 32'hCAFE_F00D},
        {2'd1, 16'h3404, 32'hFFFF_FFFF, 4'h0, 1'b1, 1'b0, 32'h0000_0000},
        {2'd0, 16'h3404, 32'h0000_0000, 4'h0, 1'b1, 1'b0, 32'hCAFE_F00D}
    };

    localparam string TAGS [NV] = '{
        "R1", "R8", "R2", "R4", "R6", "R3", "R5", "R5", "R8", "R8", "R4",
        "R7", "R7", "R7", "R7", "R6", "R8", "R3", "R8", "R10", "R10"
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_we = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [3:0]    req_be = '0;
    logic          fill_valid = 1'b0;
    logic [AW-1:0] fill_addr = '0;
    logic [DW-1:0] fill_data = '0;
    logic          rsp_ready;
    logic          rsp_miss;
    logic [DW-1:0] rsp_rdata;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    wr_pipe_top u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_we(req_we), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_be(req_be),
        .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_data(fill_data),
        .rsp_ready(rsp_ready), .rsp_miss(rsp_miss), .rsp_rdata(rsp_rdata)
    );

    task automatic check(input string tag, input logic er, input logic em,
                         input logic [DW-1:0] ed);
        n_chk++;
        if (rsp_ready !== er || rsp_miss !== em || rsp_rdata !== ed) begin
            n_bad++;
            $display("FAIL %s: got ready=%0b miss=%0b rdata=%h, expected ready=%0b miss=%0b rdata=%h",
                     tag, rsp_ready, rsp_miss, rsp_rdata, er, em, ed);
        end
    endtask

    // Drive one cycle at the falling edge; sample 2 ns later, before the rising edge.
    task automatic cyc(input logic rv, input logic we, input logic [AW-1:0] a,
                       input logic [DW-1:0] d, input logic [3:0] be,
                       input logic fv, input logic [AW-1:0] fa,
                       input logic [DW-1:0] fd);
        @(negedge clk);
        req_valid = rv; req_we = we; req_addr = a; req_wdata = d; req_be = be;
        fill_valid = fv; fill_addr = fa; fill_data = fd;
        #2;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout, expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        // R1: idle outputs during and right after reset
        cyc(1'b0, 1'b0, '0, '0, 4'h0, 1'b0, '0, '0);
        check("R1", 1'b0, 1'b0, '0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [1:0] k;
            k = VEC[i][87:86];
            if (k == 2'd2)
                cyc(1'b0, 1'b0, '0, '0, 4'h0, 1'b1, VEC[i][85:70], VEC[i][69:38]);
            else
                cyc(1'b1, k[0], VEC[i][85:70], VEC[i][69:38], VEC[i][37:34],
                    1'b0, '0, '0);
            check(TAGS[i], VEC[i][33], VEC[i][32], VEC[i][31:0]);
        end

        // R9: an idle cycle carrying store-like inputs is ignored
        cyc(1'b0, 1'b1, 16'h3404, 32'h0, 4'hF, 1'b0, '0, '0);
        check("R9", 1'b0, 1'b0, '0);
        cyc(1'b1, 1'b0, 16'h3404, '0, 4'h0, 1'b0, '0, '0);
        check("R9", 1'b1, 1'b0, 32'hCAFE_F00D);

        // R8: a request alongside a fill is reported as a miss
        cyc(1'b1, 1'b0, 16'h3404, '0, 4'h0, 1'b1, 16'h1210, 32'h0BAD_0BAD);
        check("R8", 1'b0, 1'b1, '0);
        cyc(1'b1, 1'b0, 16'h1210, '0, 4'h0, 1'b0, '0, '0);
        check("R8", 1'b1, 1'b0, 32'h0BAD_0BAD);

        // R6: a store to a fresh line parks the full mask; a neighbouring line is unaffected
        cyc(1'b1, 1'b1, 16'h1210, 32'h1357_9BDF, 4'hF, 1'b0, '0, '0);
        check("R4", 1'b1, 1'b0, '0);
        cyc(1'b1, 1'b0, 16'h1210, '0, 4'h0, 1'b0, '0, '0);
        check("R6", 1'b1, 1'b0, 32'h1357_9BDF);
        cyc(1'b1, 1'b0, 16'h3404, '0, 4'h0, 1'b0, '0, '0);
        check("R6", 1'b1, 1'b0, 32'hCAFE_F00D);

        // R1: reset invalidates every line and drops the parked write
        cyc(1'b0, 1'b0, '0, '0, 4'h0, 1'b0, '0, '0);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        cyc(1'b1, 1'b0, 16'h3404, '0, 4'h0, 1'b0, '0, '0);
        check("R1", 1'b0, 1'b1, '0);
        cyc(1'b1, 1'b1, 16'h1210, 32'h0, 4'hF, 1'b0, '0, '0);
        check("R1", 1'b0, 1'b1, '0);

        cyc(1'b0, 1'b0, '0, '0, 4'h0, 1'b0, '0, '0);
        finish_run();
    end

endmodule